// File: doc/BRIEF.md
# Vector Unit-Stride Load/Store Sequencer

This block moves one vector register between a byte-addressed memory and the vector register file. A start pulse launches a transfer. The pulse comes with a direction flag (load or store), a base address, an element count and an element-width code. The sequencer then steps through consecutive addresses and transfers one element per cycle. Loads go from memory into register slots 0, 1, 2 and onward. Stores go from those slots into memory.

The timing does not depend on the data. Two setup cycles come first. A fixed memory lead time of `LAT` cycles follows, then one cycle per element, then two closing cycles. In the last closing cycle a one-cycle done pulse is raised. A cycle counter output gives the length of the transfer, from the start cycle to the done cycle inclusive. With the default lead time of 32, a 10-element transfer takes 46 cycles.

The memory port is a plain request port. A read returns its word on `mem_rdata_i` with `mem_rvalid_i` high in the cycle after the request, with the element in the low bits. The register file is read combinationally through an index, and written through an enable, an index and data.

Top module: `vls_seq`

## Requirements
- R1: After reset `done_o`, `mem_req_o` and `vrf_wr_en_o` are 0 and `cycles_o` is 0.
- R2: A load (`store_i`=0) writes the element read at `base + i*step` into register slot i, for i from 0 to n-1. Slots at index n and above are not written.
- R3: A store (`store_i`=1) issues write requests whose address is `base + i*step` and whose `mem_wdata_o` carries the low `step` bytes of slot i. The bits above those bytes are zero. `mem_size_o` equals the width code.
- R4: The width code sets the step. Code 2'b00 gives 1 byte (8-bit elements), 2'b01 gives 2 bytes (16-bit) and 2'b10 gives 4 bytes (32-bit). Code 2'b11 behaves as 2'b10.
- R5: Loaded 8-bit and 16-bit elements are zero-extended to the full slot width, whatever the upper bits of `mem_rdata_i` hold.
- R6: For n > 0 the first request is in cycle 3+LAT, counting the start cycle as cycle 1. The done pulse is in cycle 4+LAT+n, which is 46 for n=10 and LAT=32.
- R7: Exactly n requests are issued, one in every cycle with no gaps, and `mem_we_o` equals the direction flag on each of them.
- R8: With n = 0 no request and no register write occur, and done rises in cycle 4.
- R9: `done_o` is high for exactly one cycle. `cycles_o` equals the total cycle count while done is high and holds that value until the next accepted start.
- R10: A start pulse that arrives while a transfer is in progress is ignored. The running transfer keeps its count, direction and timing.
- R11: An element count above `MAX_ELEMS` is treated as `MAX_ELEMS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| store_i | input | 1 | 1 = store, 0 = load |
| base_addr_i | input | ADDR_W | Byte address of element 0 |
| vlen_i | input | LEN_W | Element count n |
| width_i | input | 2 | Element width code |
| mem_req_o | output | 1 | Memory request, one element |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Request byte address |
| mem_size_o | output | 2 | Width code of the request |
| mem_wdata_o | output | ELEM_W | Write data, element in low bytes |
| mem_rvalid_i | input | 1 | Read data valid, one cycle after a read request |
| mem_rdata_i | input | ELEM_W | Read data, element in low bytes |
| vrf_rd_idx_o | output | IDX_W | Register slot read for a store |
| vrf_rd_data_i | input | ELEM_W | Contents of that slot |
| vrf_wr_en_o | output | 1 | Register slot write enable |
| vrf_wr_idx_o | output | IDX_W | Register slot written |
| vrf_wr_data_o | output | ELEM_W | Zero-extended loaded element |
| done_o | output | 1 | One-cycle completion pulse |
| cycles_o | output | CNT_W | Cycles from start to done |

## Verification
The assertions assume that the memory raises `mem_rvalid_i` only in the cycle after a read request, and never after a write. The element-count check relies on this, because writes to the register file follow the responses. The bench memory model registers each read request and answers it exactly one cycle later. It never answers a write. The second start pulse used to test R10 is raised only while a transfer is running. No stimulus changes the transfer inputs at an accepted start edge except through the start task itself.

// File: rtl/vls_pkg.sv
package vls_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_WAIT  = 3'd2,
        ST_XFER  = 3'd3,
        ST_DRAIN = 3'd4,
        ST_DONE  = 3'd5
    } seq_state_e;

    // Bytes per element for a width code: 00 -> 1, 01 -> 2, others -> 4.
    function automatic logic [2:0] elem_bytes(input logic [1:0] code);
        case (code)
            2'b00:   elem_bytes = 3'd1;
            2'b01:   elem_bytes = 3'd2;
            default: elem_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/vls_lane_fmt.sv
// Keeps the bytes of one element that belong to the active width and
// clears the rest; used for load zero-extension and store masking.
module vls_lane_fmt #(
    parameter int ELEM_W = 32
) (
    input  logic [1:0]        width_i,
    input  logic [ELEM_W-1:0] data_i,
    output logic [ELEM_W-1:0] data_o
);
    import vls_pkg::*;

    localparam int NLANES = ELEM_W / 8;

    logic [2:0] nbytes;
    assign nbytes = elem_bytes(width_i);

    for (genvar b = 0; b < NLANES; b++) begin : g_lane
        always_comb begin
            if (b < int'(nbytes)) data_o[8*b +: 8] = data_i[8*b +: 8];
            else                  data_o[8*b +: 8] = 8'h00;
        end
    end

endmodule

// File: rtl/vls_addr_gen.sv
// Element address register: loads the base on accept, steps by the
// element size on every issued request.
module vls_addr_gen #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              step_i,
    input  logic [1:0]        width_i,
    output logic [ADDR_W-1:0] addr_o
);
    import vls_pkg::*;

    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load_i)      addr_d = base_i;
        else if (step_i) addr_d = addr_q + ADDR_W'(elem_bytes(width_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/vls_ctrl.sv
// Sequencer state machine: setup, fixed lead time, element stream,
// drain and done; also tracks the load write index and the cycle count.
module vls_ctrl #(
    parameter int MAX_ELEMS = 32,
    parameter int LAT       = 32,
    parameter int LEN_W     = 6,
    parameter int CNT_W     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    store_i,
    input  logic [LEN_W-1:0]        vlen_i,
    input  logic [1:0]              width_i,
    input  logic                    rvalid_i,
    output logic                    accept_o,
    output logic                    issue_o,
    output logic                    wr_en_o,
    output vls_pkg::seq_state_e     state_o,
    output logic [LEN_W-1:0]        len_o,
    output logic [LEN_W-1:0]        issued_o,
    output logic [LEN_W-1:0]        wr_idx_o,
    output logic                    store_o,
    output logic [1:0]              width_o,
    output logic [CNT_W-1:0]        cycles_o
);
    import vls_pkg::*;

    localparam int LAT_W = (LAT > 1) ? $clog2(LAT) : 1;

    typedef struct packed {
        seq_state_e       st;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] issued;
        logic [LEN_W-1:0] wr_idx;
        logic [LAT_W-1:0] wait_cnt;
        logic [CNT_W-1:0] cycles;
        logic             store;
        logic [1:0]       width;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  accept, issue, wr_en;
    logic [LEN_W-1:0] len_clamped;

    always_comb begin
        if (vlen_i > LEN_W'(MAX_ELEMS)) len_clamped = LEN_W'(MAX_ELEMS);
        else                            len_clamped = vlen_i;
    end

    always_comb begin
        ctl_d  = ctl_q;
        accept = 1'b0;
        issue  = 1'b0;
        wr_en  = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    accept          = 1'b1;
                    ctl_d.st        = ST_SETUP;
                    ctl_d.len       = len_clamped;
                    ctl_d.store     = store_i;
                    ctl_d.width     = width_i;
                    ctl_d.issued    = '0;
                    ctl_d.wr_idx    = '0;
                    ctl_d.wait_cnt  = '0;
                    ctl_d.cycles    = CNT_W'(2);
                end
            end
            ST_SETUP: begin
                ctl_d.cycles = ctl_q.cycles + CNT_W'(1);
                ctl_d.st     = (ctl_q.len == '0) ? ST_DRAIN : ST_WAIT;
            end
            ST_WAIT: begin
                ctl_d.cycles = ctl_q.cycles + CNT_W'(1);
                if (ctl_q.wait_cnt == LAT_W'(LAT - 1)) ctl_d.st = ST_XFER;
                else ctl_d.wait_cnt = ctl_q.wait_cnt + LAT_W'(1);
            end
            ST_XFER: begin
                ctl_d.cycles = ctl_q.cycles + CNT_W'(1);
                issue        = 1'b1;
                ctl_d.issued = ctl_q.issued + LEN_W'(1);
                if (ctl_q.issued == ctl_q.len - LEN_W'(1)) ctl_d.st = ST_DRAIN;
            end
            ST_DRAIN: begin
                ctl_d.cycles = ctl_q.cycles + CNT_W'(1);
                ctl_d.st     = ST_DONE;
            end
            ST_DONE: begin
                ctl_d.st = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
        if (!ctl_q.store && rvalid_i &&
            (ctl_q.st == ST_XFER || ctl_q.st == ST_DRAIN)) begin
            wr_en        = 1'b1;
            ctl_d.wr_idx = ctl_q.wr_idx + LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q          <= '0;
            ctl_q.st       <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign accept_o = accept;
    assign issue_o  = issue;
    assign wr_en_o  = wr_en;
    assign state_o  = ctl_q.st;
    assign len_o    = ctl_q.len;
    assign issued_o = ctl_q.issued;
    assign wr_idx_o = ctl_q.wr_idx;
    assign store_o  = ctl_q.store;
    assign width_o  = ctl_q.width;
    assign cycles_o = ctl_q.cycles;

endmodule

// File: rtl/vls_seq.sv
module vls_seq #(
    parameter int  MAX_ELEMS = 32,
    parameter int  ELEM_W    = 32,
    parameter int  ADDR_W    = 32,
    parameter int  LAT       = 32,
    localparam int LEN_W     = $clog2(MAX_ELEMS + 1),
    localparam int IDX_W     = (MAX_ELEMS > 1) ? $clog2(MAX_ELEMS) : 1,
    localparam int CNT_W     = $clog2(MAX_ELEMS + LAT + 5) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              store_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [LEN_W-1:0]  vlen_i,
    input  logic [1:0]        width_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [1:0]        mem_size_o,
    output logic [ELEM_W-1:0] mem_wdata_o,
    input  logic              mem_rvalid_i,
    input  logic [ELEM_W-1:0] mem_rdata_i,
    output logic [IDX_W-1:0]  vrf_rd_idx_o,
    input  logic [ELEM_W-1:0] vrf_rd_data_i,
    output logic              vrf_wr_en_o,
    output logic [IDX_W-1:0]  vrf_wr_idx_o,
    output logic [ELEM_W-1:0] vrf_wr_data_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  cycles_o
);
    import vls_pkg::*;

    logic             accept, issue, wr_en, store_q, busy;
    seq_state_e       st;
    logic [LEN_W-1:0] len_q, issued_q, wr_idx_q;
    logic [1:0]       width_q;
    logic [CNT_W-1:0] cycles_q;
    logic [ADDR_W-1:0] addr_q;

    vls_ctrl #(
        .MAX_ELEMS(MAX_ELEMS), .LAT(LAT), .LEN_W(LEN_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .store_i  (store_i),
        .vlen_i   (vlen_i),
        .width_i  (width_i),
        .rvalid_i (mem_rvalid_i),
        .accept_o (accept),
        .issue_o  (issue),
        .wr_en_o  (wr_en),
        .state_o  (st),
        .len_o    (len_q),
        .issued_o (issued_q),
        .wr_idx_o (wr_idx_q),
        .store_o  (store_q),
        .width_o  (width_q),
        .cycles_o (cycles_q)
    );

    vls_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .base_i  (base_addr_i),
        .step_i  (issue),
        .width_i (width_q),
        .addr_o  (addr_q)
    );

    vls_lane_fmt #(.ELEM_W(ELEM_W)) u_ld_fmt (
        .width_i (width_q),
        .data_i  (mem_rdata_i),
        .data_o  (vrf_wr_data_o)
    );

    vls_lane_fmt #(.ELEM_W(ELEM_W)) u_st_fmt (
        .width_i (width_q),
        .data_i  (vrf_rd_data_i),
        .data_o  (mem_wdata_o)
    );

    assign busy         = (st != ST_IDLE);
    assign mem_req_o    = issue;
    assign mem_we_o     = issue & store_q;
    assign mem_addr_o   = addr_q;
    assign mem_size_o   = width_q;
    assign vrf_rd_idx_o = IDX_W'(issued_q);
    assign vrf_wr_en_o  = wr_en;
    assign vrf_wr_idx_o = IDX_W'(wr_idx_q);
    assign done_o       = (st == ST_DONE);
    assign cycles_o     = cycles_q;

endmodule

// File: rtl/vls_seq_chk.sv
module vls_seq_chk #(
    parameter int  MAX_ELEMS = 32,
    parameter int  ELEM_W    = 32,
    parameter int  ADDR_W    = 32,
    parameter int  LAT       = 32,
    localparam int LEN_W     = $clog2(MAX_ELEMS + 1),
    localparam int IDX_W     = (MAX_ELEMS > 1) ? $clog2(MAX_ELEMS) : 1,
    localparam int CNT_W     = $clog2(MAX_ELEMS + LAT + 5) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy,
    input logic              store_q,
    input logic [1:0]        width_q,
    input logic [LEN_W-1:0]  len_q,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              vrf_wr_en_o,
    input logic [IDX_W-1:0]  vrf_wr_idx_o,
    input logic [ELEM_W-1:0] vrf_wr_data_o,
    input logic              done_o,
    input logic [CNT_W-1:0]  cycles_o
);
    import vls_pkg::*;

    logic [LEN_W-1:0] req_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  req_cnt <= '0;
        else if (start_i && !busy)   req_cnt <= '0;
        else if (mem_req_o)          req_cnt <= req_cnt + LEN_W'(1);
    end

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_cycles_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_i) |=> $stable(cycles_o));

    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && $past(mem_req_o)) |->
            mem_addr_o == $past(mem_addr_o) + ADDR_W'(elem_bytes(width_q)));

    p_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vrf_wr_en_o && width_q == 2'b00) |-> vrf_wr_data_o[ELEM_W-1:8] == '0);

    p_zext16_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vrf_wr_en_o && width_q == 2'b01) |-> vrf_wr_data_o[ELEM_W-1:16] == '0);

    p_wr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vrf_wr_en_o |-> LEN_W'(vrf_wr_idx_o) < len_q);

    p_req_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> req_cnt == len_q);

    p_we_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> mem_we_o == store_q);

    p_empty_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && len_q == '0) |-> !mem_req_o);

    p_total_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && len_q != '0) |-> cycles_o == CNT_W'(4 + LAT) + CNT_W'(len_q));

    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i) |=> len_q == $past(len_q));

endmodule

bind vls_seq vls_seq_chk #(
    .MAX_ELEMS(MAX_ELEMS), .ELEM_W(ELEM_W), .ADDR_W(ADDR_W), .LAT(LAT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .busy          (busy),
    .store_q       (store_q),
    .width_q       (width_q),
    .len_q         (len_q),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .vrf_wr_en_o   (vrf_wr_en_o),
    .vrf_wr_idx_o  (vrf_wr_idx_o),
    .vrf_wr_data_o (vrf_wr_data_o),
    .done_o        (done_o),
    .cycles_o      (cycles_o)
);

// File: tb/sim_vls_seq.sv
`timescale 1ns/1ps
module sim_vls_seq;
    localparam int MAX_ELEMS = 32;
    localparam int ELEM_W    = 32;
    localparam int ADDR_W    = 32;
    localparam int LAT       = 32;
    localparam int LEN_W     = $clog2(MAX_ELEMS + 1);
    localparam int IDX_W     = $clog2(MAX_ELEMS);
    localparam int CNT_W     = $clog2(MAX_ELEMS + LAT + 5) + 1;
    localparam logic [31:0] SENT = 32'hDEADBEEF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, store_i = 1'b0;
    logic [ADDR_W-1:0] base_addr_i = '0;
    logic [LEN_W-1:0]  vlen_i = '0;
    logic [1:0]        width_i = '0;
    logic              mem_req_o, mem_we_o, mem_rvalid_i;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [1:0]        mem_size_o;
    logic [ELEM_W-1:0] mem_wdata_o, mem_rdata_i, vrf_rd_data_i, vrf_wr_data_o;
    logic [IDX_W-1:0]  vrf_rd_idx_o, vrf_wr_idx_o;
    logic              vrf_wr_en_o, done_o;
    logic [CNT_W-1:0]  cycles_o;
    logic              clr = 1'b0;

    always #5 clk = ~clk;

    vls_seq #(.MAX_ELEMS(MAX_ELEMS), .ELEM_W(ELEM_W), .ADDR_W(ADDR_W), .LAT(LAT)) u0 (.*);

    int n_chk = 0, n_bad = 0;
    int r_total, r_first, r_nreq, r_nwe, r_nwr, r_hi;

    function automatic logic [7:0] pat(input logic [7:0] a);
        return a * 8'd37 + 8'h91;
    endfunction
    function automatic logic [31:0] word_at(input logic [7:0] a);
        return {pat(a + 8'd3), pat(a + 8'd2), pat(a + 8'd1), pat(a)};
    endfunction
    function automatic logic [31:0] src(input int i);
        return 32'hC0DE0000 ^ (i * 32'h01030507);
    endfunction

    // memory and register-file models
    logic [7:0]  wmem  [256];
    logic        wflag [256];
    logic [31:0] vreg  [MAX_ELEMS];

    assign vrf_rd_data_i = src(int'(vrf_rd_idx_o));

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || clr) begin
            for (int k = 0; k < 256; k++) begin wmem[k] <= 8'h00; wflag[k] <= 1'b0; end
            for (int k = 0; k < MAX_ELEMS; k++) vreg[k] <= SENT;
            mem_rvalid_i <= 1'b0;
            mem_rdata_i  <= '0;
        end else begin
            mem_rvalid_i <= mem_req_o && !mem_we_o;
            if (mem_req_o && !mem_we_o) mem_rdata_i <= word_at(mem_addr_o[7:0]);
            if (mem_req_o && mem_we_o) begin
                for (int k = 0; k < 4; k++) begin
                    if (k < ((mem_size_o == 2'b00) ? 1 : (mem_size_o == 2'b01) ? 2 : 4)) begin
                        wmem[mem_addr_o[7:0] + 8'(k)]  <= mem_wdata_o[8*k +: 8];
                        wflag[mem_addr_o[7:0] + 8'(k)] <= 1'b1;
                    end
                end
            end
            if (vrf_wr_en_o) vreg[vrf_wr_idx_o] <= vrf_wr_data_o;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic clear_models();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    // Launch one transfer; optional second start pulse at edge pulse_at.
    task automatic run(input bit st, input logic [7:0] base, input int vl,
                       input logic [1:0] w, input int pulse_at);
        int n = 0;
        r_total = 0; r_first = 0; r_nreq = 0; r_nwe = 0; r_nwr = 0; r_hi = 0;
        @(negedge clk);
        start_i = 1'b1; store_i = st; base_addr_i = ADDR_W'(base);
        vlen_i = LEN_W'(vl); width_i = w;
        forever begin
            @(posedge clk); n++;
            @(negedge clk);
            start_i = 1'b0;
            if (n == pulse_at) begin
                start_i = 1'b1; store_i = 1'b1; vlen_i = LEN_W'(5);
                base_addr_i = 32'hE0; width_i = 2'b00;
            end
            if (mem_req_o) begin
                r_nreq++;
                if (r_first == 0) r_first = n + 1;
                if (mem_we_o) r_nwe++;
                if (mem_we_o && w == 2'b00 && mem_wdata_o[31:8] != 24'h0) r_hi++;
            end
            if (vrf_wr_en_o) r_nwr++;
            if (done_o) begin r_total = n + 1; break; end
            if (n > 3000) begin
                chk("watchdog in run", 32'(n), 32'd0);
                break;
            end
        end
        start_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 done", 32'(done_o), 0);
        chk("R1 req", 32'(mem_req_o), 0);
        chk("R1 wr_en", 32'(vrf_wr_en_o), 0);
        chk("R1 cycles", 32'(cycles_o), 0);
    endtask

    task automatic t_load32();
        clear_models();
        run(1'b0, 8'h10, 10, 2'b10, -1);
        chk("R6 total 10 elems", r_total, 46);
        chk("R6 first req cycle", r_first, LAT + 3);
        chk("R7 request count", r_nreq, 10);
        chk("R7 no writes on load", r_nwe, 0);
        chk("R9 cycles at done", 32'(cycles_o), 46);
        @(negedge clk);
        chk("R9 done one cycle", 32'(done_o), 0);
        for (int i = 0; i < 10; i++)
            chk($sformatf("R2 slot %0d", i), vreg[i], word_at(8'h10 + 8'(4*i)));
        chk("R2 slot 10 untouched", vreg[10], SENT);
        repeat (3) @(negedge clk);
        chk("R9 cycles held", 32'(cycles_o), 46);
    endtask

    task automatic t_load8();
        clear_models();
        run(1'b0, 8'h21, 5, 2'b00, -1);
        @(negedge clk);
        for (int i = 0; i < 5; i++)
            chk($sformatf("R5 R4 byte slot %0d", i), vreg[i], {24'h0, pat(8'h21 + 8'(i))});
        chk("R2 slot 5 untouched", vreg[5], SENT);
        chk("R6 total 5 elems", r_total, LAT + 4 + 5);
    endtask

    task automatic t_load16();
        clear_models();
        run(1'b0, 8'h40, 4, 2'b01, -1);
        @(negedge clk);
        for (int i = 0; i < 4; i++)
            chk($sformatf("R5 R4 half slot %0d", i), vreg[i],
                {16'h0, pat(8'h41 + 8'(2*i)), pat(8'h40 + 8'(2*i))});
        chk("R2 nwr", r_nwr, 4);
    endtask

    task automatic t_store32();
        clear_models();
        run(1'b1, 8'h80, 6, 2'b10, -1);
        @(negedge clk);
        chk("R6 store total", r_total, LAT + 4 + 6);
        chk("R7 store we count", r_nwe, 6);
        chk("R3 no vrf writes", r_nwr, 0);
        for (int i = 0; i < 6; i++)
            chk($sformatf("R3 word %0d", i),
                {wmem[8'h83 + 8'(4*i)], wmem[8'h82 + 8'(4*i)],
                 wmem[8'h81 + 8'(4*i)], wmem[8'h80 + 8'(4*i)]}, src(i));
        chk("R3 past end untouched", 32'(wflag[8'h98]), 0);
        chk("R3 before base untouched", 32'(wflag[8'h7F]), 0);
    endtask

    task automatic t_store8();
        clear_models();
        run(1'b1, 8'hC3, 7, 2'b00, -1);
        @(negedge clk);
        for (int i = 0; i < 7; i++)
            chk($sformatf("R3 R4 byte %0d", i), 32'(wmem[8'hC3 + 8'(i)]), 32'(src(i)[7:0]));
        chk("R3 byte past end", 32'(wflag[8'hCA]), 0);
        chk("R3 upper wdata zero", r_hi, 0);
    endtask

    task automatic t_empty();
        clear_models();
        run(1'b0, 8'h10, 0, 2'b10, -1);
        chk("R8 total", r_total, 4);
        chk("R8 requests", r_nreq, 0);
        chk("R8 writes", r_nwr, 0);
        @(negedge clk);
        chk("R8 slot 0 untouched", vreg[0], SENT);
    endtask

    task automatic t_clamp();
        clear_models();
        run(1'b0, 8'h00, 40, 2'b11, -1);
        @(negedge clk);
        chk("R11 requests", r_nreq, MAX_ELEMS);
        chk("R11 total", r_total, LAT + 4 + MAX_ELEMS);
        chk("R4 code 11 last slot", vreg[MAX_ELEMS-1], word_at(8'(4*(MAX_ELEMS-1))));
    endtask

    task automatic t_busy_start();
        clear_models();
        run(1'b0, 8'h10, 3, 2'b10, 5);
        @(negedge clk);
        chk("R10 total unchanged", r_total, LAT + 4 + 3);
        chk("R10 request count", r_nreq, 3);
        chk("R10 no store", r_nwe, 0);
        chk("R10 slots written", r_nwr, 3);
        chk("R10 second base untouched", 32'(wflag[8'hE0]), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load32();
        t_load8();
        t_load16();
        t_store32();
        t_store8();
        t_empty();
        t_clamp();
        t_busy_start();
        finish_run();
    end

    initial begin
        #(200000 * 10);
        chk("watchdog expired", 32'd1, 32'd0);
        finish_run();
    end

endmodule